// File: doc/BRIEF.md
# DMA Minor-Loop Bandwidth Throttle

This block sits beside a DMA engine's transfer sequencer and limits how fast the engine issues bus accesses inside a minor loop. Without it the engine runs its read/write pairs back to back until the minor count runs out. The sequencer pulses an access-done input each time a read or a write completes. The block answers with a registered stall output that holds off the next access for a number of idle cycles. A 2-bit throttle code picks that number.

Two places in a minor loop get no stall when the source and destination sizes are equal. The first is the boundary between the first and second transfers. The sequencer marks it by raising the first-access indicator with the done pulse. The second is the point after the last write of the loop. The sequencer marks it with the last-write indicator on a write's done pulse. A minor-loop start pulse ends any stall still running, so each new loop begins without one.

Top module: `dma_bw_throttle`

## Requirements
- R1: While reset is high and in the first cycle after it, `stall` is low.
- R2: With code 2'b00 (off) or the reserved code 2'b01, an accepted access-done pulse produces no stall cycle.
- R3: With code 2'b10, an accepted access-done pulse raises `stall` in the next cycle and holds it high for exactly 4 cycles, for a read or a write alike.
- R4: With code 2'b11, an accepted access-done pulse raises `stall` in the next cycle and holds it high for exactly 8 cycles.
- R5: When `size_match` is high, a done pulse that arrives with `first_acc` high produces no stall. When `size_match` is low, the same pulse is throttled normally.
- R6: When `size_match` is high, a write's done pulse that arrives with `last_wr` high produces no stall. A read marked `last_wr`, or any pulse with `size_match` low, is throttled normally.
- R7: The code is sampled only with the accepted done pulse. Changing `bw_code` while a stall runs does not change the length of that stall.
- R8: A done pulse that arrives while `stall` is high is ignored. It neither restarts nor lengthens the running stall.
- R9: A `loop_start` pulse drives `stall` low in the next cycle. A done pulse in the same cycle as `loop_start` is ignored.
- R10: A done pulse in the first cycle after `stall` falls is accepted, and `stall` rises again one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bw_code | input | 2 | Throttle code: 00 off, 01 reserved (acts as off), 10 medium, 11 heavy |
| acc_done | input | 1 | One-cycle pulse when a bus access completes |
| acc_is_write | input | 1 | Qualifies `acc_done`: 1 for a write, 0 for a read |
| first_acc | input | 1 | Qualifies `acc_done`: the access ends the first transfer of the minor loop |
| last_wr | input | 1 | Qualifies `acc_done`: the access is the final write of the minor loop |
| size_match | input | 1 | Source and destination transfer sizes are equal |
| loop_start | input | 1 | One-cycle pulse when a minor loop begins |
| stall | output | 1 | Registered hold-off for the next bus access |

## Verification
Every result here is due one clock after the pulse that causes it. The only register between an accepted done pulse or a `loop_start` and `stall` is the stall flop itself. A stall of length N therefore covers the N cycles that start one edge after the pulse. The bench drives inputs and samples `stall` on the falling edge. A behavioural model counts remaining stall cycles on each rising edge and is compared with `stall` at every falling edge. Directed tasks also count the run length of `stall`, starting at the first falling edge after the pulse. A stall that starts late, ends early, or is restarted by an ignored pulse therefore shows up as a wrong count.

// File: rtl/dma_bw_pkg.sv
package dma_bw_pkg;

  typedef enum logic [1:0] {
    BW_OFF  = 2'b00,
    BW_RSVD = 2'b01,
    BW_MID  = 2'b10,
    BW_HIGH = 2'b11
  } bw_code_e;

  typedef struct packed {
    logic is_write;
    logic first;
    logic last_wr;
  } acc_tag_t;

endpackage

// File: rtl/dma_bw_len_sel.sv
module dma_bw_len_sel
  import dma_bw_pkg::*;
#(
  parameter int LEN_MID  = 4,
  parameter int LEN_HIGH = 8,
  parameter int LW       = 4
) (
  input  logic [1:0]    code,
  output logic [LW-1:0] len
);

  always_comb begin
    unique case (bw_code_e'(code))
      BW_MID:  len = LW'(LEN_MID);
      BW_HIGH: len = LW'(LEN_HIGH);
      default: len = '0;   // off and reserved both mean no stall
    endcase
  end

endmodule

// File: rtl/dma_bw_skip_qual.sv
module dma_bw_skip_qual
  import dma_bw_pkg::*;
(
  input  acc_tag_t tag,
  input  logic     size_match,
  output logic     skip
);

  logic at_first_boundary;
  logic at_loop_tail;

  assign at_first_boundary = tag.first;
  assign at_loop_tail      = tag.is_write & tag.last_wr;
  assign skip              = size_match & (at_first_boundary | at_loop_tail);

endmodule

// File: rtl/dma_bw_stall_timer.sv
module dma_bw_stall_timer #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cancel,
  input  logic          load,
  input  logic [LW-1:0] load_len,
  output logic          busy
);

  logic [LW-1:0] remain_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
    end else if (busy_q) begin
      if (remain_q == '0) busy_q <= 1'b0;
      else                remain_q <= remain_q - LW'(1);
    end else if (load) begin
      busy_q   <= 1'b1;
      remain_q <= load_len - LW'(1);
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/dma_bw_throttle.sv
module dma_bw_throttle
  import dma_bw_pkg::*;
#(
  parameter int LEN_MID  = 4,
  parameter int LEN_HIGH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bw_code,
  input  logic       acc_done,
  input  logic       acc_is_write,
  input  logic       first_acc,
  input  logic       last_wr,
  input  logic       size_match,
  input  logic       loop_start,
  output logic       stall
);

  localparam int LW = $clog2(LEN_HIGH + 1);

  acc_tag_t      tag;
  logic [LW-1:0] code_len;
  logic          skip;
  logic          accept;
  logic          load;

  assign tag.is_write = acc_is_write;
  assign tag.first    = first_acc;
  assign tag.last_wr  = last_wr;

  dma_bw_len_sel #(
    .LEN_MID (LEN_MID),
    .LEN_HIGH(LEN_HIGH),
    .LW      (LW)
  ) u_len (
    .code(bw_code),
    .len (code_len)
  );

  dma_bw_skip_qual u_skip (
    .tag       (tag),
    .size_match(size_match),
    .skip      (skip)
  );

  // a pulse is taken only when idle and not colliding with a loop start
  assign accept = acc_done & ~stall & ~loop_start;
  assign load   = accept & ~skip & (code_len != '0);

  dma_bw_stall_timer #(.LW(LW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .cancel  (loop_start),
    .load    (load),
    .load_len(code_len),
    .busy    (stall)
  );

endmodule

// File: rtl/dma_bw_throttle_chk.sv
module dma_bw_throttle_chk #(
  parameter int LEN_HIGH = 8
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] bw_code,
  input logic       acc_done,
  input logic       acc_is_write,
  input logic       first_acc,
  input logic       last_wr,
  input logic       size_match,
  input logic       loop_start,
  input logic       stall
);

  localparam int RW = $clog2(LEN_HIGH + 2);
  logic [RW-1:0] run_q;
  logic          take;

  assign take = acc_done & ~stall & ~loop_start;

  always_ff @(posedge clk) begin
    if (rst || !stall) run_q <= '0;
    else if (run_q != RW'(LEN_HIGH + 1)) run_q <= run_q + RW'(1);
  end

  assert_stall_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    stall |-> (run_q < RW'(LEN_HIGH)));

  assert_off_codes_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (take && !bw_code[1]) |=> !stall);

  assert_mid_code_starts_R3: assert property (@(posedge clk) disable iff (rst)
    (take && bw_code == 2'b10 && !size_match) |=> stall);

  assert_first_skip_R5: assert property (@(posedge clk) disable iff (rst)
    (take && size_match && first_acc) |=> !stall);

  assert_tail_skip_R6: assert property (@(posedge clk) disable iff (rst)
    (take && size_match && acc_is_write && last_wr) |=> !stall);

  assert_loop_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
    loop_start |=> !stall);

  assert_rise_needs_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> $past(acc_done));

endmodule

bind dma_bw_throttle dma_bw_throttle_chk #(.LEN_HIGH(LEN_HIGH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bw_code     (bw_code),
  .acc_done    (acc_done),
  .acc_is_write(acc_is_write),
  .first_acc   (first_acc),
  .last_wr     (last_wr),
  .size_match  (size_match),
  .loop_start  (loop_start),
  .stall       (stall)
);

// File: tb/tb_dma_bw_throttle.sv
`timescale 1ns/1ps
module tb_dma_bw_throttle;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bw_code = 2'b00;
  logic       acc_done = 1'b0, acc_is_write = 1'b0, first_acc = 1'b0;
  logic       last_wr = 1'b0, size_match = 1'b0, loop_start = 1'b0;
  logic       stall;

  int checks = 0, fails = 0;
  int ref_rem = 0;
  string phase = "R1 reset";
  bit done_flag = 0;

  always #2 clk = ~clk;   // 250 MHz

  dma_bw_throttle dut (
    .clk(clk), .rst(rst), .bw_code(bw_code), .acc_done(acc_done),
    .acc_is_write(acc_is_write), .first_acc(first_acc), .last_wr(last_wr),
    .size_match(size_match), .loop_start(loop_start), .stall(stall)
  );

  function automatic int code_len(input logic [1:0] c);
    if (c == 2'b10) return 4;
    if (c == 2'b11) return 8;
    return 0;
  endfunction

  // behavioural reference: cycles of stall still owed
  always @(posedge clk) begin
    if (rst || loop_start) ref_rem = 0;
    else if (ref_rem > 0) ref_rem = ref_rem - 1;
    else if (acc_done) begin
      if (size_match && (first_acc || (acc_is_write && last_wr))) ref_rem = 0;
      else ref_rem = code_len(bw_code);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      checks++;
      if (stall !== (ref_rem > 0)) begin
        fails++;
        $display("FAIL %s model: stall=%0b expected=%0b", phase, stall, ref_rem > 0);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] c, input logic wr, input logic fst,
                       input logic lst, input logic mt);
    @(negedge clk);
    bw_code = c; acc_is_write = wr; first_acc = fst; last_wr = lst; size_match = mt;
    acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0; first_acc = 1'b0; last_wr = 1'b0;
  endtask

  // counts stall-high falling edges starting right after the pulse
  task automatic count_run(output int n);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (stall) n++;
      else break;
      @(negedge clk);
    end
  endtask

  task automatic run_case(input string req, input logic [1:0] c, input logic wr,
                          input logic fst, input logic lst, input logic mt, input int exp);
    int n;
    phase = req;
    pulse(c, wr, fst, lst, mt);
    count_run(n);
    check(req, n, exp);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_up;
    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int n;
    repeat (2) @(negedge clk);
    check("R1 during reset", stall, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", stall, 0);

    run_case("R2 code 00", 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    run_case("R2 code 01", 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    run_case("R3 code 10 read", 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 4);
    run_case("R3 code 10 write", 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 4);
    run_case("R4 code 11", 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 8);
    run_case("R5 first matched", 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 0);
    run_case("R5 first unmatched", 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 4);
    run_case("R6 last write matched", 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 0);
    run_case("R6 last read matched", 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8);
    run_case("R6 last write unmatched", 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 8);

    // R7: code changes mid-stall
    phase = "R7 code change";
    pulse(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    bw_code = 2'b11;
    count_run(n);
    check("R7 length kept", n, 4);
    repeat (2) @(negedge clk);

    // R8: pulse during stall ignored
    phase = "R8 pulse during stall";
    pulse(2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;
    n = 2;
    for (int i = 0; i < 20; i++) begin
      if (stall) n++;
      else break;
      @(negedge clk);
    end
    check("R8 run length", n, 4);
    @(negedge clk);
    check("R8 stays low", stall, 0);
    repeat (2) @(negedge clk);

    // R9: loop start cancels
    phase = "R9 cancel";
    pulse(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    loop_start = 1'b1;
    @(negedge clk);
    loop_start = 1'b0;
    check("R9 cancelled", stall, 0);
    @(negedge clk);
    phase = "R9 same-cycle pulse";
    bw_code = 2'b11; loop_start = 1'b1; acc_done = 1'b1;
    @(negedge clk);
    loop_start = 1'b0; acc_done = 1'b0;
    check("R9 pulse with start ignored", stall, 0);
    repeat (2) @(negedge clk);

    // R10: back-to-back acceptance
    phase = "R10 back to back";
    pulse(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    count_run(n);
    check("R10 first run", n, 4);
    acc_done = 1'b1; acc_is_write = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;
    check("R10 restall", stall, 1);
    count_run(n);
    check("R10 second run", n, 4);
    repeat (3) @(negedge clk);

    finish_up();
  end

endmodule